// File: doc/BRIEF.md
# Capacitance Difference Calibrate/Measure Sequencer

This block orders the switch and DAC phases of a charge-redistribution readout. The readout compares a sense capacitor with a reference capacitor, and both share one top node. The block drives the bottom-plate switch of the reference capacitor (S1), the bottom-plate switch of the sense capacitor (S2) and the top-node reset switch (S3). It also selects the DAC source and starts an external successive-approximation engine.

Each run has two passes:

- A calibration pass. It converts the charge from switch injection and comparator offset, then stores that code.
- A measurement pass. It preloads the two's-complement negation of the stored code through the DAC while the top node is held in reset. The measurement code then tracks the reference capacitance minus the sense capacitance.

When residual-charge mode is requested, a second calibrate/measure pair follows with the two capacitors' roles exchanged. The two measurement codes are summed. The reset switch either closes the amplifier feedback loop (closed-loop mode) or ties the node to ground (open-loop mode).

A run starts with a single-cycle `start` pulse. The run's options are captured on that pulse. Phase changes are separated by a programmable settle interval and a break-before-make cycle. The status flags report either a valid result or a range error. A range error is raised when the calibration code sits at full scale.

Top module: `capdiff_seq`

## Requirements
- R1: After reset the block is in the following state:
  - both plate controls are 2'b00 (open), S3 is open and the DAC select is 2'b00 (ground);
  - `busy`, `res_valid`, `range_err` and `sar_start` are all 0.
- R2: The calibration pass uses these settings:
  - during its reset phase, S3 is closed, S1 is 2'b01 (ground), S2 is 2'b10 (reference) and the DAC select is 2'b00;
  - during its conversion phase, S3 is open, the plates keep those levels and the DAC select is 2'b01 (SAR code).
- R3: The measurement pass uses these settings:
  - during its reset phase, S3 is closed, S1 is 2'b10, S2 is 2'b01 and the DAC select is 2'b10 (preload);
  - during its conversion phase, S3 is open, S1 is 2'b01, S2 is 2'b10 and the DAC select is 2'b01.
- R4: The preload value is the two's-complement negation of the calibration code stored by the same pair. `cal_code` shows the most recently stored calibration code.
- R5: `s3_gnd` is 1 in every cycle in which S3 is closed during an open-loop run. It is 0 throughout a closed-loop run.
- R6: In residual mode the run has a second pair in which S1 and S2 exchange their levels in every phase. `meas_result` is the sign-extended sum of the two measurement codes. Without residual mode it is the single measurement code.
- R7: Each reset phase holds its switch settings for at least `settle_cnt`+1 cycles. `sar_start` pulses for one cycle, no earlier than the (`settle_cnt`+1)-th cycle of a conversion phase.
- R8: Between any two phases there is at least one cycle with both plates open, S3 open and the DAC at ground. No plate ever moves directly from ground to reference or from reference to ground.
- R9: A calibration code equal to the most positive or most negative code value has these effects:
  - `range_err` is set;
  - the run ends without any measurement phase;
  - `res_valid` stays 0.
- R10: `res_valid` rises when a run completes, and both status flags clear on the start of the next run. A `start` pulse while `busy` is ignored.
- R11: `sar_done` is ignored unless a conversion that this block launched is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (single-cycle pulse) |
| open_loop | input | 1 | 1 = open-loop reset, 0 = closed-loop; captured at start |
| residual_mode | input | 1 | 1 = add the swapped-role pair; captured at start |
| settle_cnt | input | SETTLE_W | Settle interval in cycles |
| sar_start | output | 1 | Launch pulse for the SAR engine |
| sar_done | input | 1 | SAR engine conversion finished |
| sar_code | input | CODE_W | Signed SAR result |
| s1_ctl | output | 2 | Reference plate: 00 open, 01 ground, 10 reference |
| s2_ctl | output | 2 | Sense plate: 00 open, 01 ground, 10 reference |
| s3_close | output | 1 | Top-node reset switch closed |
| s3_gnd | output | 1 | Reset ties node to ground (open-loop) |
| dac_sel | output | 2 | DAC source: 00 ground, 01 SAR code, 10 preload |
| dac_preload | output | CODE_W | Negated calibration code for the DAC |
| cal_code | output | CODE_W | Last stored calibration code |
| meas_result | output | CODE_W+1 | Summed measurement result |
| res_valid | output | 1 | Result valid |
| range_err | output | 1 | Calibration saturated, run aborted |
| busy | output | 1 | Run in progress |

## Verification
The bench builds the block with the following parameter values:

| Parameter | Value |
|---|---|
| CODE_W | 8 |
| SETTLE_W | 4 |
| RESIDUAL_EN | 1 |
| SAT_GUARD | 0 |

With an 8-bit code, both full-scale codes (127 and -128) can be driven directly. This exercises the abort path, and the negated preload (251, 7, 253) can be checked bit for bit. Enabling the residual variant brings the swapped-role pair and the summed result within reach. A settle count of 5 gives a window long enough to inject a second `start` and a stray `sar_done` before any conversion is pending. The zero-guard saturation variant keeps the range error tied to the two exact full-scale codes.

// File: rtl/cds_pkg.sv
package cds_pkg;

   typedef enum logic [2:0] {
      PH_IDLE      = 3'd0,
      PH_BREAK     = 3'd1,
      PH_CAL_RST   = 3'd2,
      PH_CAL_CONV  = 3'd3,
      PH_MEAS_RST  = 3'd4,
      PH_MEAS_CONV = 3'd5
   } phase_e;

   typedef enum logic [1:0] {
      PLATE_OPEN = 2'b00,
      PLATE_GND  = 2'b01,
      PLATE_REF  = 2'b10
   } plate_e;

   typedef enum logic [1:0] {
      DAC_GND = 2'b00,
      DAC_SAR = 2'b01,
      DAC_PRE = 2'b10
   } dacsrc_e;

endpackage

// File: rtl/cds_settle_timer.sv
module cds_settle_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   if (W < 1 || W > 16) begin : g_chk_w
      $error("cds_settle_timer: W out of range");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   // R7: a freshly loaded non-zero interval cannot report expiry on the next cycle
   p_fresh_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/cds_phase_fsm.sv
module cds_phase_fsm
   import cds_pkg::*;
#(
   parameter bit RESIDUAL_EN = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   residual_req,
   input  logic   expired,
   input  logic   sar_done,
   input  logic   sat,
   output phase_e phase,
   output logic   swap,
   output logic   sar_start,
   output logic   load_tmr,
   output logic   cal_capture,
   output logic   meas_capture,
   output logic   run_begin,
   output logic   fin_ok,
   output logic   fin_err,
   output logic   busy
);

   phase_e state_q, state_d, after_q, after_d;
   logic   swap_q, swap_d;
   logic   launched_q;
   logic   resid_q;
   logic   resid_take;

   if (RESIDUAL_EN) begin : g_resid_on
      assign resid_take = residual_req;
   end else begin : g_resid_off
      assign resid_take = 1'b0;
   end

   always_comb begin
      state_d      = state_q;
      after_d      = after_q;
      swap_d       = swap_q;
      sar_start    = 1'b0;
      cal_capture  = 1'b0;
      meas_capture = 1'b0;
      run_begin    = 1'b0;
      fin_ok       = 1'b0;
      fin_err      = 1'b0;
      case (state_q)
         PH_IDLE: begin
            if (start) begin
               state_d   = PH_BREAK;
               after_d   = PH_CAL_RST;
               swap_d    = 1'b0;
               run_begin = 1'b1;
            end
         end
         PH_BREAK: begin
            state_d = after_q;
         end
         PH_CAL_RST: begin
            if (expired) begin
               state_d = PH_BREAK;
               after_d = PH_CAL_CONV;
            end
         end
         PH_CAL_CONV: begin
            sar_start = expired && !launched_q;
            if (launched_q && sar_done) begin
               cal_capture = 1'b1;
               if (sat) begin
                  fin_err = 1'b1;
                  state_d = PH_IDLE;
               end else begin
                  state_d = PH_BREAK;
                  after_d = PH_MEAS_RST;
               end
            end
         end
         PH_MEAS_RST: begin
            if (expired) begin
               state_d = PH_BREAK;
               after_d = PH_MEAS_CONV;
            end
         end
         PH_MEAS_CONV: begin
            sar_start = expired && !launched_q;
            if (launched_q && sar_done) begin
               meas_capture = 1'b1;
               if (resid_q && !swap_q) begin
                  state_d = PH_BREAK;
                  after_d = PH_CAL_RST;
                  swap_d  = 1'b1;
               end else begin
                  fin_ok  = 1'b1;
                  state_d = PH_IDLE;
               end
            end
         end
         default: state_d = PH_IDLE;
      endcase
      load_tmr = (state_d != state_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= PH_IDLE;
         after_q    <= PH_IDLE;
         swap_q     <= 1'b0;
         launched_q <= 1'b0;
         resid_q    <= 1'b0;
      end else begin
         state_q    <= state_d;
         after_q    <= after_d;
         swap_q     <= swap_d;
         launched_q <= (state_d != state_q) ? 1'b0 : (launched_q | sar_start);
         if (run_begin) resid_q <= resid_take;
      end
   end

   assign phase = state_q;
   assign swap  = swap_q;
   assign busy  = (state_q != PH_IDLE);

   // R7: a launch only happens once the settle interval has run out
   p_launch_after_settle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sar_start |-> expired);
   // R11: a single launch per conversion phase
   p_single_launch_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sar_start |=> !sar_start);
   // R11: results are only taken on a done from the engine
   p_capture_on_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_capture || meas_capture) |-> sar_done);
   // R10: a run only begins from idle
   p_begin_from_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      run_begin |-> !busy);

endmodule

// File: rtl/cds_switch_map.sv
module cds_switch_map
   import cds_pkg::*;
(
   input  phase_e  phase,
   input  logic    swap,
   input  logic    open_loop,
   output plate_e  s1_ctl,
   output plate_e  s2_ctl,
   output logic    s3_close,
   output logic    s3_gnd,
   output dacsrc_e dac_sel
);

   plate_e ref_pl, sns_pl;

   always_comb begin
      ref_pl   = PLATE_OPEN;
      sns_pl   = PLATE_OPEN;
      s3_close = 1'b0;
      dac_sel  = DAC_GND;
      case (phase)
         PH_CAL_RST: begin
            s3_close = 1'b1;
            ref_pl   = PLATE_GND;
            sns_pl   = PLATE_REF;
            dac_sel  = DAC_GND;
         end
         PH_CAL_CONV: begin
            ref_pl  = PLATE_GND;
            sns_pl  = PLATE_REF;
            dac_sel = DAC_SAR;
         end
         PH_MEAS_RST: begin
            s3_close = 1'b1;
            ref_pl   = PLATE_REF;
            sns_pl   = PLATE_GND;
            dac_sel  = DAC_PRE;
         end
         PH_MEAS_CONV: begin
            ref_pl  = PLATE_GND;
            sns_pl  = PLATE_REF;
            dac_sel = DAC_SAR;
         end
         default: ;
      endcase
      s1_ctl = swap ? sns_pl : ref_pl;
      s2_ctl = swap ? ref_pl : sns_pl;
      s3_gnd = s3_close & open_loop;
   end

endmodule

// File: rtl/cds_result_store.sv
module cds_result_store #(
   parameter int CODE_W    = 10,
   parameter int SAT_GUARD = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] sar_code,
   input  logic              cal_capture,
   input  logic              meas_capture,
   input  logic              meas_clear,
   output logic              sat,
   output logic [CODE_W-1:0] cal_code,
   output logic [CODE_W-1:0] preload,
   output logic [CODE_W:0]   meas_sum
);

   localparam int SUM_W = CODE_W + 1;
   localparam logic [CODE_W-1:0] CODE_MAX = {1'b0, {(CODE_W-1){1'b1}}};
   localparam logic [CODE_W-1:0] CODE_MIN = {1'b1, {(CODE_W-1){1'b0}}};

   if (SAT_GUARD < 0 || SAT_GUARD >= (2 ** (CODE_W - 2))) begin : g_chk_guard
      $error("cds_result_store: SAT_GUARD out of range");
   end

   if (SAT_GUARD == 0) begin : g_sat_exact
      assign sat = (sar_code == CODE_MAX) || (sar_code == CODE_MIN);
   end else begin : g_sat_band
      localparam int HI_LIM = (2 ** (CODE_W - 1)) - 1 - SAT_GUARD;
      localparam int LO_LIM = SAT_GUARD - (2 ** (CODE_W - 1));
      logic signed [31:0] code_ext;
      assign code_ext = 32'($signed(sar_code));
      assign sat = (code_ext >= HI_LIM) || (code_ext <= LO_LIM);
   end

   logic [CODE_W-1:0] cal_q;
   logic [SUM_W-1:0]  sum_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cal_q <= '0;
         sum_q <= '0;
      end else begin
         if (cal_capture) cal_q <= sar_code;
         if (meas_clear) begin
            sum_q <= '0;
         end else if (meas_capture) begin
            sum_q <= sum_q + {sar_code[CODE_W-1], sar_code};
         end
      end
   end

   assign cal_code = cal_q;
   assign preload  = '0 - cal_q;
   assign meas_sum = sum_q;

   // R6: the result only moves on a clear or a captured measurement
   p_sum_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!meas_capture && !meas_clear) |=> $stable(meas_sum));
   // R4: the stored calibration code only moves on a capture
   p_cal_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !cal_capture |=> $stable(cal_code));

endmodule

// File: rtl/capdiff_seq.sv
module capdiff_seq
   import cds_pkg::*;
#(
   parameter int CODE_W      = 10,
   parameter int SETTLE_W    = 8,
   parameter bit RESIDUAL_EN = 1'b1,
   parameter int SAT_GUARD   = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                open_loop,
   input  logic                residual_mode,
   input  logic [SETTLE_W-1:0] settle_cnt,
   output logic                sar_start,
   input  logic                sar_done,
   input  logic [CODE_W-1:0]   sar_code,
   output logic [1:0]          s1_ctl,
   output logic [1:0]          s2_ctl,
   output logic                s3_close,
   output logic                s3_gnd,
   output logic [1:0]          dac_sel,
   output logic [CODE_W-1:0]   dac_preload,
   output logic [CODE_W-1:0]   cal_code,
   output logic [CODE_W:0]     meas_result,
   output logic                res_valid,
   output logic                range_err,
   output logic                busy
);

   if (CODE_W < 4 || CODE_W > 24) begin : g_chk_code
      $error("capdiff_seq: CODE_W out of range");
   end

   phase_e  phase;
   logic    swap, load_tmr, expired;
   logic    cal_capture, meas_capture, run_begin, fin_ok, fin_err, sat;
   logic    open_q, valid_q, err_q;
   plate_e  s1_pl, s2_pl;
   dacsrc_e dac_src;

   cds_settle_timer #(.W(SETTLE_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_tmr),
      .load_val (settle_cnt),
      .expired  (expired)
   );

   cds_phase_fsm #(.RESIDUAL_EN(RESIDUAL_EN)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .residual_req (residual_mode),
      .expired      (expired),
      .sar_done     (sar_done),
      .sat          (sat),
      .phase        (phase),
      .swap         (swap),
      .sar_start    (sar_start),
      .load_tmr     (load_tmr),
      .cal_capture  (cal_capture),
      .meas_capture (meas_capture),
      .run_begin    (run_begin),
      .fin_ok       (fin_ok),
      .fin_err      (fin_err),
      .busy         (busy)
   );

   cds_switch_map u_map (
      .phase     (phase),
      .swap      (swap),
      .open_loop (open_q),
      .s1_ctl    (s1_pl),
      .s2_ctl    (s2_pl),
      .s3_close  (s3_close),
      .s3_gnd    (s3_gnd),
      .dac_sel   (dac_src)
   );

   cds_result_store #(.CODE_W(CODE_W), .SAT_GUARD(SAT_GUARD)) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .sar_code     (sar_code),
      .cal_capture  (cal_capture),
      .meas_capture (meas_capture),
      .meas_clear   (run_begin),
      .sat          (sat),
      .cal_code     (cal_code),
      .preload      (dac_preload),
      .meas_sum     (meas_result)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q  <= 1'b0;
         valid_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         if (run_begin) begin
            open_q  <= open_loop;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
         end
         if (fin_ok)  valid_q <= 1'b1;
         if (fin_err) err_q   <= 1'b1;
      end
   end

   assign s1_ctl    = s1_pl;
   assign s2_ctl    = s2_pl;
   assign dac_sel   = dac_src;
   assign res_valid = valid_q;
   assign range_err = err_q;

   // R8: a driven plate either keeps its level or opens first
   p_bbm_s1_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_ctl != 2'b00) |=> (s1_ctl == $past(s1_ctl)) || (s1_ctl == 2'b00));
   p_bbm_s2_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_ctl != 2'b00) |=> (s2_ctl == $past(s2_ctl)) || (s2_ctl == 2'b00));
   // R8: leaving reset passes through an all-open cycle
   p_reset_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      s3_close |=> s3_close || (s1_ctl == 2'b00 && s2_ctl == 2'b00 && dac_sel == 2'b00));
   // R2: conversions run with the node floating and the DAC on the SAR code
   p_conv_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sar_start |-> (!s3_close && dac_sel == 2'b01));
   // R4: the preload cancels the stored calibration code
   p_preload_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_sel == 2'b10) |-> ((dac_preload + cal_code) == '0));
   // R5: ground tie only while the reset switch is closed
   p_gnd_tie_r5: assert property (@(posedge clk) disable iff (!rst_n)
      s3_gnd |-> s3_close);
   // R9: the two status outcomes exclude each other
   p_status_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_valid && range_err));
   // R10: a new run starts with the valid flag cleared
   p_valid_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !$past(busy)) |-> !res_valid);

endmodule

// File: tb/capdiff_seq_test.sv
`timescale 1ns/1ps
module capdiff_seq_test;

   localparam int CW = 8;
   localparam int SW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          open_loop = 1'b0;
   logic          residual_mode = 1'b0;
   logic [SW-1:0] settle_cnt = '0;
   logic          sar_start;
   logic          sar_done;
   logic [CW-1:0] sar_code;
   logic [1:0]    s1_ctl, s2_ctl, dac_sel;
   logic          s3_close, s3_gnd;
   logic [CW-1:0] dac_preload, cal_code;
   logic [CW:0]   meas_result;
   logic          res_valid, range_err, busy;

   logic          done_resp = 1'b0, done_spur = 1'b0;
   logic [CW-1:0] code_resp = '0, code_spur = '0;
   assign sar_done = done_resp | done_spur;
   assign sar_code = done_spur ? code_spur : code_resp;

   always #4 clk = ~clk;

   capdiff_seq #(.CODE_W(CW), .SETTLE_W(SW), .RESIDUAL_EN(1'b1), .SAT_GUARD(0)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .open_loop(open_loop),
      .residual_mode(residual_mode), .settle_cnt(settle_cnt),
      .sar_start(sar_start), .sar_done(sar_done), .sar_code(sar_code),
      .s1_ctl(s1_ctl), .s2_ctl(s2_ctl), .s3_close(s3_close), .s3_gnd(s3_gnd),
      .dac_sel(dac_sel), .dac_preload(dac_preload), .cal_code(cal_code),
      .meas_result(meas_result), .res_valid(res_valid), .range_err(range_err),
      .busy(busy)
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   // logs of reset runs and conversion snapshots
   int rl_s1[0:63], rl_s2[0:63], rl_gnd[0:63], rl_dac[0:63], rl_pre[0:63];
   int rl_n = 0;
   int cv_s1[0:63], cv_s2[0:63], cv_s3[0:63], cv_dac[0:63];
   int cv_n = 0;
   int bbm_err = 0, set_err = 0;
   logic [CW-1:0] code_list[0:3];
   int conv_base = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: runs of constant switch configuration
   initial begin : mon
      logic [15:0] prev, cur;
      int run;
      prev = '0;
      run  = 0;
      forever begin
         @(negedge clk);
         cur = {s1_ctl, s2_ctl, s3_close, s3_gnd, dac_sel, dac_preload};
         if (cur == prev) begin
            run++;
         end else begin
            if ((prev[15:12] != 0 || prev[11]) && (cur[15:12] != 0 || cur[11])) bbm_err++;
            if (prev[11]) begin
               rl_s1[rl_n & 63]  = int'(prev[15:14]);
               rl_s2[rl_n & 63]  = int'(prev[13:12]);
               rl_gnd[rl_n & 63] = int'(prev[10]);
               rl_dac[rl_n & 63] = int'(prev[9:8]);
               rl_pre[rl_n & 63] = int'(prev[7:0]);
               rl_n++;
               if (run < int'(settle_cnt) + 1) set_err++;
            end
            run = 1;
         end
         if (rst_n && sar_start && run < int'(settle_cnt) + 1) set_err++;
         prev = cur;
      end
   end

   // SAR engine model
   initial begin : resp
      forever begin
         @(negedge clk);
         if (rst_n && sar_start) begin
            cv_s1[cv_n & 63]  = int'(s1_ctl);
            cv_s2[cv_n & 63]  = int'(s2_ctl);
            cv_s3[cv_n & 63]  = int'(s3_close);
            cv_dac[cv_n & 63] = int'(dac_sel);
            cv_n++;
            repeat (3) @(negedge clk);
            code_resp = code_list[(cv_n - 1 - conv_base) & 3];
            done_resp = 1'b1;
            @(negedge clk);
            done_resp = 1'b0;
         end
      end
   end

   task automatic pulse_spur(input logic [CW-1:0] c);
      code_spur = c;
      done_spur = 1'b1;
      @(negedge clk);
      done_spur = 1'b0;
   endtask

   // run one sequence; poke injects a second start and a stray done mid-run
   task automatic run_seq(input bit ol, input bit res, input int settle,
                          input int c0, input int c1, input int c2, input int c3,
                          input bit poke, output int rb, output int cb,
                          output int b0, output int s0);
      int t;
      open_loop     = ol;
      residual_mode = res;
      settle_cnt    = SW'(settle);
      code_list[0]  = CW'(c0);
      code_list[1]  = CW'(c1);
      code_list[2]  = CW'(c2);
      code_list[3]  = CW'(c3);
      conv_base     = cv_n;
      rb = rl_n; cb = cv_n; b0 = bbm_err; s0 = set_err;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
      chk(res_valid == 1'b0, "R10 valid cleared at start", int'(res_valid), 0);
      chk(range_err == 1'b0, "R10 range flag cleared at start", int'(range_err), 0);
      if (poke) begin
         @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         pulse_spur(CW'(100));
      end
      t = 0;
      while (busy && t < 5000) begin
         @(negedge clk);
         t++;
      end
      chk(t < 5000, "R10 run completes", t, 0);
      repeat (6) @(negedge clk);
   endtask

   task automatic test_reset();
      chk(s1_ctl == 2'b00, "R1 s1 open", int'(s1_ctl), 0);
      chk(s2_ctl == 2'b00, "R1 s2 open", int'(s2_ctl), 0);
      chk(s3_close == 1'b0, "R1 s3 open", int'(s3_close), 0);
      chk(dac_sel == 2'b00, "R1 dac ground", int'(dac_sel), 0);
      chk({busy, res_valid, range_err, sar_start} == 4'b0, "R1 flags low",
          int'({busy, res_valid, range_err, sar_start}), 0);
   endtask

   task automatic test_closed_single();
      int rb, cb, b0, s0;
      run_seq(1'b0, 1'b0, 2, 5, -20, 0, 0, 1'b0, rb, cb, b0, s0);
      chk(cv_n - cb == 2, "R6 two conversions single mode", cv_n - cb, 2);
      chk(rl_n - rb == 2, "R2 two reset phases", rl_n - rb, 2);
      chk(rl_s1[rb & 63] == 1 && rl_s2[rb & 63] == 2 && rl_dac[rb & 63] == 0,
          "R2 cal reset config", rl_s1[rb & 63] * 100 + rl_s2[rb & 63] * 10 + rl_dac[rb & 63], 120);
      chk(cv_s1[cb & 63] == 1 && cv_s2[cb & 63] == 2 && cv_s3[cb & 63] == 0 && cv_dac[cb & 63] == 1,
          "R2 cal conversion config", cv_s1[cb & 63] * 100 + cv_s2[cb & 63] * 10 + cv_dac[cb & 63], 121);
      chk(rl_s1[(rb + 1) & 63] == 2 && rl_s2[(rb + 1) & 63] == 1 && rl_dac[(rb + 1) & 63] == 2,
          "R3 meas reset config",
          rl_s1[(rb + 1) & 63] * 100 + rl_s2[(rb + 1) & 63] * 10 + rl_dac[(rb + 1) & 63], 212);
      chk(cv_s1[(cb + 1) & 63] == 1 && cv_s2[(cb + 1) & 63] == 2 && cv_dac[(cb + 1) & 63] == 1,
          "R3 meas conversion config",
          cv_s1[(cb + 1) & 63] * 100 + cv_s2[(cb + 1) & 63] * 10 + cv_dac[(cb + 1) & 63], 121);
      chk(rl_pre[(rb + 1) & 63] == 251, "R4 preload is negated cal", rl_pre[(rb + 1) & 63], 251);
      chk(cal_code == 8'd5, "R4 cal code stored", int'(cal_code), 5);
      chk(rl_gnd[rb & 63] == 0 && rl_gnd[(rb + 1) & 63] == 0, "R5 closed loop no ground tie",
          rl_gnd[rb & 63] + rl_gnd[(rb + 1) & 63], 0);
      chk(int'($signed(meas_result)) == -20, "R6 single result", int'($signed(meas_result)), -20);
      chk(res_valid == 1'b1 && range_err == 1'b0, "R10 valid at end", int'(res_valid), 1);
      chk(bbm_err == b0, "R8 break before make", bbm_err - b0, 0);
      chk(set_err == s0, "R7 settle honoured", set_err - s0, 0);
   endtask

   task automatic test_open_residual();
      int rb, cb, b0, s0;
      run_seq(1'b1, 1'b1, 0, -7, 30, 3, -12, 1'b0, rb, cb, b0, s0);
      chk(cv_n - cb == 4, "R6 four conversions residual mode", cv_n - cb, 4);
      chk(rl_n - rb == 4, "R6 four reset phases", rl_n - rb, 4);
      chk(rl_s1[(rb + 2) & 63] == 2 && rl_s2[(rb + 2) & 63] == 1 && rl_dac[(rb + 2) & 63] == 0,
          "R6 swapped cal reset",
          rl_s1[(rb + 2) & 63] * 100 + rl_s2[(rb + 2) & 63] * 10 + rl_dac[(rb + 2) & 63], 210);
      chk(cv_s1[(cb + 2) & 63] == 2 && cv_s2[(cb + 2) & 63] == 1, "R6 swapped cal conversion",
          cv_s1[(cb + 2) & 63] * 10 + cv_s2[(cb + 2) & 63], 21);
      chk(rl_s1[(rb + 3) & 63] == 1 && rl_s2[(rb + 3) & 63] == 2 && rl_dac[(rb + 3) & 63] == 2,
          "R6 swapped meas reset",
          rl_s1[(rb + 3) & 63] * 100 + rl_s2[(rb + 3) & 63] * 10 + rl_dac[(rb + 3) & 63], 122);
      chk(cv_s1[(cb + 3) & 63] == 2 && cv_s2[(cb + 3) & 63] == 1, "R6 swapped meas conversion",
          cv_s1[(cb + 3) & 63] * 10 + cv_s2[(cb + 3) & 63], 21);
      chk(rl_pre[(rb + 1) & 63] == 7, "R4 preload first pair", rl_pre[(rb + 1) & 63], 7);
      chk(rl_pre[(rb + 3) & 63] == 253, "R4 preload second pair", rl_pre[(rb + 3) & 63], 253);
      chk(rl_gnd[rb & 63] + rl_gnd[(rb + 1) & 63] + rl_gnd[(rb + 2) & 63] + rl_gnd[(rb + 3) & 63] == 4,
          "R5 open loop ground tie",
          rl_gnd[rb & 63] + rl_gnd[(rb + 1) & 63] + rl_gnd[(rb + 2) & 63] + rl_gnd[(rb + 3) & 63], 4);
      chk(int'($signed(meas_result)) == 18, "R6 summed result", int'($signed(meas_result)), 18);
      chk(cal_code == 8'd3, "R4 last cal code", int'(cal_code), 3);
      chk(res_valid == 1'b1, "R10 valid residual", int'(res_valid), 1);
      chk(bbm_err == b0, "R8 break before make residual", bbm_err - b0, 0);
      chk(set_err == s0, "R7 settle zero", set_err - s0, 0);
   endtask

   task automatic test_range(input int cval, input string tag);
      int rb, cb, b0, s0;
      run_seq(1'b1, 1'b1, 1, cval, 1, 1, 1, 1'b0, rb, cb, b0, s0);
      chk(range_err == 1'b1, {"R9 range flag ", tag}, int'(range_err), 1);
      chk(res_valid == 1'b0, {"R9 no valid ", tag}, int'(res_valid), 0);
      chk(cv_n - cb == 1, {"R9 no measurement conversion ", tag}, cv_n - cb, 1);
      chk(rl_n - rb == 1, {"R9 no measurement reset ", tag}, rl_n - rb, 1);
      chk(cal_code == CW'(cval), {"R9 saturated code kept ", tag}, int'(cal_code), cval & 255);
   endtask

   task automatic test_ignored_inputs();
      int rb, cb, b0, s0;
      pulse_spur(CW'(77));
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R11 stray done while idle", int'(busy), 0);
      chk(cal_code == 8'h80, "R11 stray done leaves cal", int'(cal_code), 128);
      chk(range_err == 1'b1 && res_valid == 1'b0, "R11 stray done leaves status",
          int'(range_err), 1);
      run_seq(1'b0, 1'b0, 5, 2, 9, 0, 0, 1'b1, rb, cb, b0, s0);
      chk(cv_n - cb == 2, "R10 restart ignored while busy", cv_n - cb, 2);
      chk(int'($signed(meas_result)) == 9, "R11 stray done before launch ignored",
          int'($signed(meas_result)), 9);
      chk(cal_code == 8'd2, "R11 cal from real conversion", int'(cal_code), 2);
      chk(set_err == s0, "R7 settle five", set_err - s0, 0);
      chk(bbm_err == b0, "R8 break before make settle five", bbm_err - b0, 0);
   endtask

   initial begin : wdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      test_reset();
      test_closed_single();
      test_open_residual();
      test_range(127, "max");
      test_range(-128, "min");
      test_ignored_inputs();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule